// File: doc/BRIEF.md
# Errored Second Monitor

This block marks out one-second intervals on a receive path and records each interval in which at least one enabled line-error event occurred. Event detection happens elsewhere. Eight single-cycle event strobes arrive from the framer logic, and each strobe has its own enable bit. The one-second boundary has two possible sources, picked by a configuration input:

- a divider that counts receive-clock cycles, where the count is a parameter: 2,048,000 by default, or a small value for simulation;
- an external second pulse, assumed already synchronous to the clock.

Two status bits are kept:

| Bit | Name | Set when |
|-----|------|----------|
| 0 | second-timer | at every boundary |
| 1 | errored-second | at a boundary that closes an interval containing an enabled event |

Each status bit has a mask bit. A visibility input lets masked bits still be recorded without affecting the interrupt. A read strobe clears both status bits. The interrupt output, which is also the global summary, is high while any unmasked status bit is set.

Top module: `es_monitor`

## Requirements
- R1: With `sel_ext`=0, a boundary occurs every SEC_CYCLES clock cycles after reset. Each boundary sets `status[0]` one cycle later (second-timer bit).
- R2: With `sel_ext`=1, a boundary occurs exactly on the cycles where `ext_sec`=1, and the internal divider produces none.
- R3: At a boundary, `status[1]` (errored-second) is set only if `err_evt & err_en` was non-zero on some cycle of the interval just ended. The `err_evt` bits are:

  | Bit | Event |
  |-----|-------|
  | 0 | lost frame alignment |
  | 1 | framing error |
  | 2 | CRC error |
  | 3 | alarm indication signal |
  | 4 | loss of signal |
  | 5 | code violation |
  | 6 | receive slip |
  | 7 | E-bit error |

- R4: An event whose `err_en` bit is 0 has no effect on `status[1]`.
- R5: An event on the same cycle as a boundary is counted in the new interval, not in the one that is ending.
- R6: A cycle with `rd_stb`=1 clears both status bits on the next cycle.
- R7: A status bit that is set on the same cycle as `rd_stb` is still 1 after that read.
- R8: When `irq_mask[k]`=1, `status[k]` is recorded only if `show_masked`=1, and a recorded masked bit never drives `irq`.
- R9: `irq` is 1 exactly while some `status[k]` with `irq_mask[k]`=0 is 1.
- R10: During and right after reset, `status`=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_ext | input | 1 | 1: boundaries from `ext_sec`; 0: from the internal divider |
| ext_sec | input | 1 | External one-cycle second pulse |
| err_evt | input | 8 | Single-cycle line-error event strobes |
| err_en | input | 8 | Per-event enable |
| irq_mask | input | 2 | Mask per status bit, where 1 means masked |
| show_masked | input | 1 | Record masked status bits anyway |
| rd_stb | input | 1 | Status read strobe that clears status |
| status | output | 2 | {errored-second, second-timer} |
| irq | output | 1 | Interrupt and global summary |

## Verification
Each event line is pulsed alone in two runs. In one run only that line is enabled. In the other run every line except that one is enabled. This separates a correct per-line gate from a swapped or missing one. An event placed on the boundary cycle, followed by a quiet interval, shows which interval the event is charged to. A sweep of all mask and visibility combinations, with both statuses pending, separates recording from interrupt gating. The internal divider is measured against the expected period over two boundaries. It is then shown to stay silent in external mode.

// File: rtl/es_monitor.sv
module es_monitor #(
  parameter int unsigned SEC_CYCLES = 2048000,
  parameter int unsigned NSRC       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_ext,
  input  logic            ext_sec,
  input  logic [NSRC-1:0] err_evt,
  input  logic [NSRC-1:0] err_en,
  input  logic [1:0]      irq_mask,
  input  logic            show_masked,
  input  logic            rd_stb,
  output logic [1:0]      status,
  output logic            irq
);
  localparam int CW = (SEC_CYCLES > 2) ? $clog2(SEC_CYCLES) : 1;

  logic [CW-1:0] cnt;
  logic          acc;

  wire div_done = (cnt == CW'(SEC_CYCLES - 1));
  wire tick     = sel_ext ? ext_sec : div_done;
  wire hit      = |(err_evt & err_en);

  wire [1:0] set_now = {tick & acc, tick};
  wire [1:0] keep    = ~irq_mask | {2{show_masked}};

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= div_done ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= 1'b0;
    else if (tick) acc <= hit;
    else           acc <= acc | hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= 2'b00;
    else        status <= (rd_stb ? 2'b00 : status) | (set_now & keep);
  end

  assign irq = |(status & ~irq_mask);
endmodule

module es_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       rd_stb,
  input logic [1:0] status,
  input logic [1:0] irq_mask,
  input logic       show_masked,
  input logic       irq
);
  p_sec_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !irq_mask[0]) |=> status[0]);

  p_only_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((status & ~$past(status)) == 2'b00));

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !tick) |=> (status == 2'b00));

  p_keep_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && tick && (!irq_mask[0] || show_masked)) |=> status[0]);

  p_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask[0] && !show_masked && (rd_stb || !status[0])) |=> !status[0]);

  p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b00) |-> !irq);

  p_all_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == 2'b11) |-> !irq);
endmodule

bind es_monitor es_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rd_stb(rd_stb), .status(status),
  .irq_mask(irq_mask), .show_masked(show_masked), .irq(irq)
);

// File: tb/es_monitor_test.sv
`timescale 1ns/1ps
module es_monitor_test;
  localparam int SEC = 10;

  logic clk = 0, rst_n = 0, sel_ext = 0, ext_sec = 0, show_masked = 0, rd_stb = 0;
  logic [7:0] err_evt = 0, err_en = 0;
  logic [1:0] irq_mask = 0;
  logic [1:0] status;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  es_monitor #(.SEC_CYCLES(SEC)) uut (
    .clk(clk), .rst_n(rst_n), .sel_ext(sel_ext), .ext_sec(ext_sec),
    .err_evt(err_evt), .err_en(err_en), .irq_mask(irq_mask),
    .show_masked(show_masked), .rd_stb(rd_stb), .status(status), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic ext_tick(); ext_sec = 1; step(); ext_sec = 0; endtask
  task automatic rd(); rd_stb = 1; step(); rd_stb = 0; endtask
  task automatic pulse(logic [7:0] e); err_evt = e; step(); err_evt = 0; endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int first, second;
    repeat (3) step();
    check("R10 status in reset", status, 0);
    check("R10 irq in reset", irq, 0);
    rst_n = 1;
    first = 0; second = 0;
    for (int n = 1; n <= 3 * SEC; n++) begin
      step();
      if (n == 1) check("R10 status after reset", status, 0);
      if (status[0] && first == 0) begin
        first = n;
        check("R9 irq with unmasked second", irq, 1);
        rd();
        n++;
        check("R6 read clears", status, 0);
      end else if (status[0] && second == 0) second = n;
    end
    check("R1 first boundary", first, SEC);
    check("R1 second boundary", second, 2 * SEC);

    sel_ext = 1;
    rd();
    repeat (3 * SEC) step();
    check("R2 divider silent in external mode", status, 0);
    ext_tick();
    check("R2 external pulse is a boundary", status, 1);
    rd();

    for (int i = 0; i < 8; i++) begin
      for (int pol = 0; pol < 2; pol++) begin
        err_en = pol ? ~(8'd1 << i) : (8'd1 << i);
        ext_tick(); rd();
        pulse(8'd1 << i);
        step(); step();
        ext_tick();
        if (pol == 0) check("R3 enabled source flags errored second", status, 3);
        else          check("R4 disabled source ignored", status, 1);
        rd();
      end
    end

    err_en = 8'h00;
    ext_tick(); rd();
    pulse(8'hFF);
    ext_tick();
    check("R4 all sources disabled", status, 1);
    rd();

    err_en = 8'hFF;
    ext_tick(); rd();
    err_evt = 8'h08; ext_sec = 1; step(); err_evt = 0; ext_sec = 0;
    check("R5 boundary event not in old interval", status, 1);
    rd();
    ext_tick();
    check("R5 boundary event in new interval", status, 3);
    rd();

    ext_tick();
    check("R7 setup", status, 1);
    rd_stb = 1; ext_sec = 1; step(); rd_stb = 0; ext_sec = 0;
    check("R7 set on read cycle survives", status, 1);
    rd();
    check("R6 read clears after R7", status, 0);

    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        logic [1:0] exp;
        irq_mask = m[1:0]; show_masked = s[0];
        rd(); ext_tick(); rd();
        pulse(8'h01);
        ext_tick();
        exp = 2'b11 & (~m[1:0] | {2{s[0]}});
        check("R8 recorded status per mask and visibility", status, exp);
        check("R9 irq from unmasked bits", irq, (exp & ~m[1:0]) != 0);
        rd();
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule